// File: doc/BRIEF.md
# Audio Serial Bit-Clock and Frame Generator

This block is the clocking and framing core of a stereo serial audio master. It takes a fast kernel clock and produces the bit clock, the word-select line and an optional master clock. The bit clock is made by a divider whose ratio is a prescaler value times two plus one extra bit, so odd ratios are possible. In transmit mode the block shifts a left/right sample pair out on the serial data line. In receive mode it captures one pair from the data line and presents it with a one-cycle valid pulse.

Software, or any other controller, puts the whole configuration on the input ports and then raises the enable. The configuration is latched in the cycle the block starts. Clearing the enable stops the block cleanly, but only after the current frame is finished. Word select leads the data by one bit, and samples travel MSB first.

Top module: `i2s_master_gen`

## Requirements
- R1: While running, the bit period is N = 2*psc_i + odd_i kernel cycles, taken from the values latched at start (`{psc_i, odd_i}` read as a binary number).
- R2: Each bit slot opens with the CK edge toward the idle level. CK stays at the idle level for ceil(N/2) kernel cycles and at the opposite level for floor(N/2) kernel cycles. Only rising kernel-clock edges are used.
- R3: A frame has 2L slots. L is 16 when ch32_i=0, and then bits [15:0] of each sample word are used. L is 32 when ch32_i=1.
- R4: ws_o is 0 for the left channel and 1 for the right channel. It changes at a slot start, one slot before the MSB of each channel: it is 1 in slots L-1 to 2L-2 and 0 otherwise. ws_o is 0 while idle.
- R5: In transmit mode (tx_mode_i=1), sd_o carries the left word and then the right word, MSB first, and changes at slot starts. The words are taken from tx_left_i/tx_right_i in the cycle the frame starts. sd_o is 0 in receive mode and while idle.
- R6: In receive mode (tx_mode_i=0), sd_i is sampled in the kernel cycle in which CK leaves its idle level. In the cycle after the last kernel cycle of a frame, rx_left_o and rx_right_o show the two words (a 16-bit channel is zero-extended), and rx_valid_o is high for exactly that one cycle.
- R7: While idle, ck_o equals cpol_i. While running, its idle level is the cpol_i value latched at start.
- R8: When psc_i is 0 or 1, en_i is ignored: busy_o stays 0 and CK stays idle.
- R9: When en_i=1, the block is idle and psc_i>=2, busy_o rises in the next cycle and slot 0 begins. After en_i is cleared, busy_o falls only after the last kernel cycle of a frame, so a run always lasts a whole number of frames.
- R10: mck_o is 0 while idle or when the master-clock enable latched at start was 0. Otherwise it starts at 0 in the first running cycle and toggles on every kernel cycle.
- R11: After reset, busy_o, ws_o, sd_o, mck_o and rx_valid_o are 0, and ck_o equals cpol_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run request |
| tx_mode_i | input | 1 | 1 = transmit, 0 = receive |
| ch32_i | input | 1 | Channel length: 1 = 32 bits, 0 = 16 bits |
| cpol_i | input | 1 | Idle level of CK |
| psc_i | input | 8 | Prescaler value |
| odd_i | input | 1 | Odd-ratio extension bit |
| mck_en_i | input | 1 | Master-clock output enable |
| tx_left_i | input | 32 | Left sample to send |
| tx_right_i | input | 32 | Right sample to send |
| sd_i | input | 1 | Serial data in (receive mode) |
| ck_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| sd_o | output | 1 | Serial data out (transmit mode) |
| mck_o | output | 1 | Master clock |
| busy_o | output | 1 | Block is running |
| rx_left_o | output | 32 | Last received left word |
| rx_right_o | output | 32 | Last received right word |
| rx_valid_o | output | 1 | One-cycle pulse when a received pair is published |

## Verification
The end of a frame is the cycle where several things can coincide: the slot counter wraps, a new sample pair is reloaded or a received pair is published, and a pending stop takes effect. The bench makes these collide by dropping en_i at different points inside a frame, in both transmit and receive mode. A behavioural per-cycle model predicts every output on every clock. Separate checks confirm that each run lasts a whole number of frames, that the published words match the pattern the bench drove, and that the word reloaded at a frame boundary is the one present in that cycle.

// File: rtl/i2s_pkg.sv
package i2s_pkg;
  localparam int unsigned PSC_W   = 8;
  localparam int unsigned DIV_W   = PSC_W + 1;
  localparam int unsigned SLOT_W  = 32;
  localparam int unsigned SHORT_W = 16;
  localparam int unsigned FRAME_W = 2 * SLOT_W;
  localparam int unsigned BIT_W   = $clog2(FRAME_W);

  typedef struct packed {
    logic [PSC_W-1:0] psc;
    logic             odd;
    logic             ch32;
    logic             cpol;
    logic             tx;
    logic             mck;
  } cfg_t;
endpackage

// File: rtl/i2s_clk_div.sv
module i2s_clk_div
  import i2s_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             slot_end_o,
  output logic             rise_o,
  output logic             lead_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] hi_start;

  // idle-level phase gets the extra cycle on odd ratios
  assign hi_start   = div_i - (div_i >> 1);
  assign slot_end_o = run_i && (cnt_q == div_i - 1'b1);
  assign rise_o     = run_i && (cnt_q == hi_start);
  assign lead_o     = run_i && (cnt_q >= hi_start);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run_i || slot_end_o) cnt_q <= '0;
    else                           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/i2s_frame_ctrl.sv
module i2s_frame_ctrl
  import i2s_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             en_i,
  input  logic             slot_end_i,
  input  logic             ch32_i,
  output logic             run_o,
  output logic             frame_end_o,
  output logic             ws_o
);
  logic             run_q;
  logic [BIT_W-1:0] bit_q;
  logic [BIT_W-1:0] last_bit;
  logic [BIT_W-1:0] ws_lo;

  assign last_bit    = ch32_i ? BIT_W'(FRAME_W - 1) : BIT_W'(2 * SHORT_W - 1);
  assign ws_lo       = ch32_i ? BIT_W'(SLOT_W - 1)  : BIT_W'(SHORT_W - 1);
  assign frame_end_o = slot_end_i && (bit_q == last_bit);
  // WS leads the channel MSB by one slot
  assign ws_o        = run_q && (bit_q >= ws_lo) && (bit_q < last_bit);
  assign run_o       = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      bit_q <= '0;
    end else if (start_i) begin
      run_q <= 1'b1;
      bit_q <= '0;
    end else if (slot_end_i) begin
      bit_q <= frame_end_o ? '0 : bit_q + 1'b1;
      if (frame_end_o && !en_i) run_q <= 1'b0;
    end
  end
endmodule

// File: rtl/i2s_shifter.sv
module i2s_shifter
  import i2s_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              load_ch32_i,
  input  logic [SLOT_W-1:0] tx_left_i,
  input  logic [SLOT_W-1:0] tx_right_i,
  input  logic              shift_i,
  input  logic              sample_i,
  input  logic              sd_i,
  input  logic              publish_i,
  input  logic              ch32_i,
  output logic              sd_bit_o,
  output logic [SLOT_W-1:0] rx_left_o,
  output logic [SLOT_W-1:0] rx_right_o,
  output logic              rx_valid_o
);
  logic [FRAME_W-1:0] tx_sh_q, tx_load;
  logic [FRAME_W-1:0] rx_sh_q, rx_nx;

  assign tx_load  = load_ch32_i ? {tx_left_i, tx_right_i}
                                : {tx_left_i[SHORT_W-1:0], tx_right_i[SHORT_W-1:0], {SLOT_W{1'b0}}};
  assign sd_bit_o = tx_sh_q[FRAME_W-1];
  assign rx_nx    = sample_i ? {rx_sh_q[FRAME_W-2:0], sd_i} : rx_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tx_sh_q <= '0;
    else if (load_i)   tx_sh_q <= tx_load;
    else if (shift_i)  tx_sh_q <= {tx_sh_q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_sh_q    <= '0;
      rx_left_o  <= '0;
      rx_right_o <= '0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_sh_q    <= rx_nx;
      rx_valid_o <= publish_i;
      if (publish_i) begin
        if (ch32_i) begin
          rx_left_o  <= rx_nx[FRAME_W-1:SLOT_W];
          rx_right_o <= rx_nx[SLOT_W-1:0];
        end else begin
          rx_left_o  <= {{(SLOT_W-SHORT_W){1'b0}}, rx_nx[2*SHORT_W-1:SHORT_W]};
          rx_right_o <= {{(SLOT_W-SHORT_W){1'b0}}, rx_nx[SHORT_W-1:0]};
        end
      end
    end
  end
endmodule

// File: rtl/i2s_master_gen.sv
module i2s_master_gen
  import i2s_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic        tx_mode_i,
  input  logic        ch32_i,
  input  logic        cpol_i,
  input  logic [7:0]  psc_i,
  input  logic        odd_i,
  input  logic        mck_en_i,
  input  logic [31:0] tx_left_i,
  input  logic [31:0] tx_right_i,
  input  logic        sd_i,
  output logic        ck_o,
  output logic        ws_o,
  output logic        sd_o,
  output logic        mck_o,
  output logic        busy_o,
  output logic [31:0] rx_left_o,
  output logic [31:0] rx_right_o,
  output logic        rx_valid_o
);
  cfg_t cfg_q;
  logic run, start, slot_end, rise, lead, frame_end, sd_bit, mck_q;
  logic cpol_q, tx_q;

  assign start  = !run && en_i && (psc_i >= PSC_W'(2));
  assign cpol_q = cfg_q.cpol;
  assign tx_q   = cfg_q.tx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= '0;
    else if (start) cfg_q <= '{psc: psc_i, odd: odd_i, ch32: ch32_i, cpol: cpol_i,
                               tx: tx_mode_i, mck: mck_en_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mck_q <= 1'b0;
    else         mck_q <= (run && cfg_q.mck) ? !mck_q : 1'b0;
  end

  i2s_clk_div u_div (
    .clk_i, .rst_ni,
    .run_i      (run),
    .div_i      ({cfg_q.psc, cfg_q.odd}),
    .slot_end_o (slot_end),
    .rise_o     (rise),
    .lead_o     (lead)
  );

  i2s_frame_ctrl u_frame (
    .clk_i, .rst_ni,
    .start_i     (start),
    .en_i        (en_i),
    .slot_end_i  (slot_end),
    .ch32_i      (cfg_q.ch32),
    .run_o       (run),
    .frame_end_o (frame_end),
    .ws_o        (ws_o)
  );

  i2s_shifter u_shift (
    .clk_i, .rst_ni,
    .load_i      (start || (frame_end && en_i)),
    .load_ch32_i (start ? ch32_i : cfg_q.ch32),
    .tx_left_i   (tx_left_i),
    .tx_right_i  (tx_right_i),
    .shift_i     (slot_end),
    .sample_i    (rise),
    .sd_i        (sd_i),
    .publish_i   (frame_end && !cfg_q.tx),
    .ch32_i      (cfg_q.ch32),
    .sd_bit_o    (sd_bit),
    .rx_left_o   (rx_left_o),
    .rx_right_o  (rx_right_o),
    .rx_valid_o  (rx_valid_o)
  );

  assign ck_o   = run ? (lead ^ cfg_q.cpol) : cpol_i;
  assign sd_o   = run && cfg_q.tx && sd_bit;
  assign mck_o  = mck_q;
  assign busy_o = run;
endmodule

// File: rtl/i2s_master_chk.sv
module i2s_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [7:0] psc_i,
  input logic       cpol_i,
  input logic       ck_o,
  input logic       ws_o,
  input logic       sd_o,
  input logic       mck_o,
  input logic       busy_o,
  input logic       rx_valid_o,
  input logic       cpol_q,
  input logic       tx_q
);
  AST_IDLE_CK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ck_o == cpol_i); // R7
  AST_LOW_PSC_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && psc_i < 8'd2) |=> !busy_o); // R8
  AST_VALID_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && en_i && psc_i >= 8'd2) |=> busy_o); // R9
  AST_STOP_NEEDS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !$past(en_i) && !$past(ws_o)); // R9
  AST_WS_AT_IDLE_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && ws_o != $past(ws_o)) |-> ck_o == cpol_q); // R4
  AST_RX_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R6
  AST_SD_QUIET_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tx_q) |-> !sd_o); // R5
  AST_MCK_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> !mck_o); // R10
endmodule

bind i2s_master_gen i2s_master_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .psc_i      (psc_i),
  .cpol_i     (cpol_i),
  .ck_o       (ck_o),
  .ws_o       (ws_o),
  .sd_o       (sd_o),
  .mck_o      (mck_o),
  .busy_o     (busy_o),
  .rx_valid_o (rx_valid_o),
  .cpol_q     (cpol_q),
  .tx_q       (tx_q)
);

// File: tb/i2s_master_gen_bench.sv
`timescale 1ns/1ps
module i2s_master_gen_bench;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        en_i = 0, tx_mode_i = 0, ch32_i = 0, cpol_i = 0, odd_i = 0, mck_en_i = 0, sd_i = 0;
  logic [7:0]  psc_i = 0;
  logic [31:0] tx_left_i = 0, tx_right_i = 0;
  logic        ck_o, ws_o, sd_o, mck_o, busy_o, rx_valid_o;
  logic [31:0] rx_left_o, rx_right_o;

  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  logic [31:0] rx_l = 0, rx_r = 0;

  // reference model state
  bit m_run, m_cpol, m_tx, m_mck, m_mckt, m_rxv;
  int m_n, m_L, m_cnt, m_bit;
  logic [31:0] m_l, m_r, m_rxl, m_rxr;

  i2s_master_gen u_i2s_master_gen (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_run = 0; m_cnt = 0; m_bit = 0; m_mckt = 0; m_rxv = 0; m_n = 4; m_L = 16;
      m_rxl = 0; m_rxr = 0; m_tx = 0; m_mck = 0; m_cpol = 0; m_l = 0; m_r = 0;
    end else begin
      cyc++;
      m_mckt = (m_run && m_mck) ? !m_mckt : 1'b0;
      m_rxv = 0;
      if (!m_run) begin
        if (en_i && psc_i >= 2) begin
          m_run = 1; m_n = 2 * psc_i + odd_i; m_L = ch32_i ? 32 : 16;
          m_cpol = cpol_i; m_tx = tx_mode_i; m_mck = mck_en_i;
          m_l = tx_left_i; m_r = tx_right_i; m_cnt = 0; m_bit = 0;
        end
      end else if (m_cnt == m_n - 1) begin
        m_cnt = 0;
        if (m_bit == 2 * m_L - 1) begin
          m_bit = 0;
          if (!m_tx) begin
            m_rxv = 1;
            m_rxl = (m_L == 32) ? rx_l : {16'h0, rx_l[15:0]};
            m_rxr = (m_L == 32) ? rx_r : {16'h0, rx_r[15:0]};
          end
          if (!en_i) m_run = 0;
          else begin m_l = tx_left_i; m_r = tx_right_i; end
        end else m_bit++;
      end else m_cnt++;
    end
  end

  function automatic bit exp_ck();
    if (!m_run) return cpol_i;
    return bit'(m_cnt >= m_n - m_n / 2) ^ m_cpol;
  endfunction
  function automatic bit exp_ws();
    return m_run && m_bit >= m_L - 1 && m_bit <= 2 * m_L - 2;
  endfunction
  function automatic bit frame_bit(input logic [31:0] l, input logic [31:0] r);
    return (m_bit < m_L) ? l[m_L - 1 - m_bit] : r[2 * m_L - 1 - m_bit];
  endfunction

  bit checking = 0;
  bit prev_ck, prev_ws, prev_busy, have_rise, have_ws;
  int last_rise, last_ws, run_start;

  always @(negedge clk_i) begin
    if (rst_ni && checking) begin
      bit ok;
      ok = (ck_o == exp_ck()) && (ws_o == exp_ws()) && (busy_o == m_run) && (mck_o == m_mckt)
        && (sd_o == (m_run && m_tx && frame_bit(m_l, m_r))) && (rx_valid_o == m_rxv)
        && (!m_rxv || (rx_left_o == m_rxl && rx_right_o == m_rxr));
      if (ck_o != exp_ck()) chk(0, "R2 ck_o", ck_o, exp_ck());
      else if (ws_o != exp_ws()) chk(0, "R4 ws_o", ws_o, exp_ws());
      else if (sd_o != (m_run && m_tx && frame_bit(m_l, m_r))) chk(0, "R5 sd_o", sd_o, !sd_o);
      else if (busy_o != m_run) chk(0, "R9 busy_o", busy_o, m_run);
      else if (mck_o != m_mckt) chk(0, "R10 mck_o", mck_o, m_mckt);
      else if (rx_valid_o != m_rxv) chk(0, "R6 rx_valid_o", rx_valid_o, m_rxv);
      else if (!ok) chk(0, "R6 rx words", {rx_left_o, rx_right_o}, {m_rxl, m_rxr});
      else chk(1, "model", 0, 0);
      // R1: bit period between leading edges
      if (busy_o && prev_busy && ck_o != m_cpol && prev_ck == m_cpol) begin
        if (have_rise) chk(cyc - last_rise == m_n, "R1 bit period", cyc - last_rise, m_n);
        have_rise = 1; last_rise = cyc;
      end
      // R3: frame length between WS rises
      if (busy_o && ws_o && !prev_ws) begin
        if (have_ws) chk(cyc - last_ws == 2 * m_L * m_n, "R3 frame length", cyc - last_ws, 2 * m_L * m_n);
        have_ws = 1; last_ws = cyc;
      end
      if (busy_o && !prev_busy) begin run_start = cyc; have_rise = 0; have_ws = 0; end
      if (!busy_o && prev_busy)
        chk((cyc - run_start) % (2 * m_L * m_n) == 0, "R9 whole frames", cyc - run_start, 2 * m_L * m_n);
      prev_ck = ck_o; prev_ws = ws_o; prev_busy = busy_o;
    end
    sd_i <= (m_run && !m_tx) ? frame_bit(rx_l, rx_r) : 1'b0;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask
  task automatic wait_idle();
    while (busy_o) step(1);
    step(2);
  endtask
  task automatic launch(input bit tx, input bit c32, input bit pol, input int psc, input bit odd, input bit mck);
    tx_mode_i = tx; ch32_i = c32; cpol_i = pol; psc_i = 8'(psc); odd_i = odd; mck_en_i = mck;
    en_i = 1;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    step(4);
    rst_ni = 1;
    step(3);
    checking = 1;
    @(negedge clk_i); #0.5;
    chk(busy_o == 0 && ws_o == 0 && sd_o == 0 && mck_o == 0 && rx_valid_o == 0, "R11 reset outputs",
        {busy_o, ws_o, sd_o, mck_o, rx_valid_o}, 0);
    chk(ck_o == cpol_i, "R11 reset ck", ck_o, cpol_i);
    step(1);

    // R8: prescaler 1 and 0 rejected
    launch(1, 0, 0, 1, 1, 1);
    step(40);
    chk(busy_o == 0, "R8 psc=1 ignored", busy_o, 0);
    psc_i = 0; cpol_i = 1;
    step(40);
    chk(busy_o == 0 && ck_o == 1, "R8 psc=0 ignored", {busy_o, ck_o}, 2'b01);
    en_i = 0; step(2);

    // transmit, 16-bit, N=5, data reload at boundary, stop mid-frame
    tx_left_i = 32'h1234_C3A5; tx_right_i = 32'hFFFF_5A0F;
    launch(1, 0, 0, 2, 1, 1);
    step(100);
    tx_left_i = 32'h0000_8001; tx_right_i = 32'h0000_7FFE;
    step(150);
    en_i = 0;
    wait_idle();
    cpol_i = 1; step(1);
    @(negedge clk_i); #0.5;
    chk(ck_o == 1, "R7 idle level follows cpol", ck_o, 1);
    step(1);

    // receive, 32-bit, N=6, cpol=1, one frame
    rx_l = 32'hDEAD_BEEF; rx_r = 32'h0F1E_2D3C;
    launch(0, 1, 1, 3, 0, 0);
    step(10);
    en_i = 0;
    wait_idle();
    chk(rx_left_o == 32'hDEAD_BEEF && rx_right_o == 32'h0F1E_2D3C, "R6 rx 32-bit words",
        {rx_left_o, rx_right_o}, {32'hDEAD_BEEF, 32'h0F1E_2D3C});

    // transmit, 32-bit, N=4, cpol=1, stop late in a frame
    tx_left_i = 32'hA5A5_0FF0; tx_right_i = 32'h8000_0001;
    launch(1, 1, 1, 2, 0, 1);
    step(250);
    en_i = 0;
    wait_idle();

    // receive, 16-bit, N=5, two frames
    rx_l = 32'h5555_A5C3; rx_r = 32'hAAAA_3C81;
    launch(0, 0, 0, 2, 1, 1);
    step(200);
    en_i = 0;
    wait_idle();
    chk(rx_left_o == 32'h0000_A5C3 && rx_right_o == 32'h0000_3C81, "R6 rx 16-bit zero-extended",
        {rx_left_o, rx_right_o}, {32'h0000_A5C3, 32'h0000_3C81});
    chk(mck_o == 0, "R10 mck off when idle", mck_o, 0);

    step(5);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule